// File: doc/BRIEF.md
# Register Context Transfer Sequencer

This block copies a sixteen-word register context between the processor register file and data memory on behalf of four explicit instructions: save the lower context, restore the lower context, save the upper context and restore the upper context. A one-cycle start pulse carries a two-bit operation code and a base effective address. The sequencer then walks the sixteen word slots of the frame in ascending address order. It issues one word-wide memory request at a time and either reads the register file and writes memory, or reads memory and writes the register file.

A save also captures the previous-context link word, and an upper save also captures the processor status word. Both arrive as plain input buses. A restore reads every slot of the frame but writes back only the general registers. The link word, status word and saved return address found in memory reach no register, and the block has no path to the link, free-pointer or status registers. A base in the peripheral region or a base that is not frame-aligned is refused with a trap, and no memory traffic follows.

Top module: `ctx_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `trap_mem`, `trap_align`, `mem_req_valid` and `rf_wr_en` are all low.
- R2: A start accepted while idle whose base has 0xF in its top four bits pulses `trap_mem` high for one cycle in the next cycle, with `trap_align` low. No memory request and no register write follow. This check takes priority over the alignment check.
- R3: A start accepted while idle whose base is outside the peripheral region and has any of bits [5:0] set pulses `trap_align` for one cycle in the next cycle. No memory request and no register write follow.
- R4: Slot k (0..15) is requested at address base+4k, in ascending k. While `mem_req_ready` is low, `mem_req_valid`, `mem_req_addr` and `mem_req_we` hold.
- R5: Operation code 0 (lower save) writes memory with the link word in slot 0 and A11 in slot 1. Slots 2..7 hold A2..A7 and slots 8..15 hold D0..D7.
- R6: Operation code 2 (upper save) writes memory with the link word in slot 0 and the status word in slot 1. Slots 2..7 hold A10..A15 and slots 8..15 hold D8..D15.
- R7: Operation code 1 (lower restore) writes slots 2..7 into A2..A7 and slots 8..15 into D0..D7. Slots 0 and 1 are read and discarded, and every other register, A11 included, keeps its value.
- R8: Operation code 3 (upper restore) writes slots 2..7 into A10..A15 and slots 8..15 into D8..D15. Slots 0 and 1 are read and discarded, and every other register keeps its value.
- R9: `done` pulses for exactly one cycle, in the cycle after the sixteenth accepted request. Exactly sixteen requests are accepted per transfer, and `busy` is low when `done` is high.
- R10: A start pulse while `busy` is high is ignored. It changes neither the transfer in progress nor the trap outputs.
- R11: `mem_req_we` is high on every request of a save (codes 0, 2) and low on every request of a restore (codes 1, 3). Register bank select 0 means address registers and 1 means data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation request |
| op | input | 2 | 0 lower save, 1 lower restore, 2 upper save, 3 upper restore |
| base_addr | input | AW | Frame base effective address |
| link_in | input | DW | Current previous-context link word |
| status_in | input | DW | Current processor status word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| trap_mem | output | 1 | Peripheral-region refusal pulse |
| trap_align | output | 1 | Misaligned-base refusal pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | AW | Word address of the request |
| mem_req_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the accepting cycle |
| rf_rd_bank | output | 1 | Read bank (0 address, 1 data) |
| rf_rd_idx | output | 4 | Read register index |
| rf_rd_data | input | DW | Combinational register read data |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_bank | output | 1 | Write bank (0 address, 1 data) |
| rf_wr_idx | output | 4 | Write register index |
| rf_wr_data | output | DW | Register write data |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `mem_rdata` and `rf_rd_data` respond combinationally within the same cycle. They also assume that nothing other than the sequencer changes the register file while a transfer runs. The bench models memory and the register file as arrays that answer in the same cycle and update on the clock edge. It drives `start` for one cycle at the falling edge and touches the register file only between transfers. The same applies to the memory, except for the memory writes the sequencer makes itself. Ready is swept between always-high and a periodic stall pattern, so that the hold rule is exercised without violating the handshake.

// File: rtl/ctx_xfer_seq.sv
module ctx_xfer_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int FRAME_WORDS = 16,
  parameter logic [3:0] PERIPH_TAG = 4'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] link_in,
  input  logic [DW-1:0] status_in,
  output logic          busy,
  output logic          done,
  output logic          trap_mem,
  output logic          trap_align,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rf_rd_bank,
  output logic [3:0]    rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_wr_en,
  output logic          rf_wr_bank,
  output logic [3:0]    rf_wr_idx,
  output logic [DW-1:0] rf_wr_data
);
  localparam int CW = $clog2(FRAME_WORDS);
  localparam int ALIGN_LSB = CW + 2;

  logic          busy_q, done_q, tm_q, ta_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] base_q;
  logic [1:0]    op_q;

  wire accept   = start && !busy_q;
  wire periph   = base_addr[AW-1 -: 4] == PERIPH_TAG;
  wire misal    = |base_addr[ALIGN_LSB-1:0];
  wire hs       = mem_req_valid && mem_req_ready;
  wire is_load  = op_q[0];
  wire upper    = op_q[1];
  wire last     = cnt_q == CW'(FRAME_WORDS - 1);
  wire [3:0] gidx = {upper, cnt_q[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tm_q   <= 1'b0;
      ta_q   <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      op_q   <= '0;
    end else begin
      done_q <= 1'b0;
      tm_q   <= accept && periph;
      ta_q   <= accept && !periph && misal;
      if (accept && !periph && !misal) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        base_q <= base_addr;
        op_q   <= op;
      end else if (hs) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy          = busy_q;
  assign done          = done_q;
  assign trap_mem      = tm_q;
  assign trap_align    = ta_q;

  assign mem_req_valid = busy_q;
  assign mem_req_we    = !is_load;
  assign mem_req_addr  = base_q | (AW'(cnt_q) << 2);

  assign rf_rd_bank    = cnt_q[3];
  assign rf_rd_idx     = (cnt_q == CW'(1)) ? 4'd11 : gidx;
  assign mem_req_wdata = (cnt_q == CW'(0)) ? link_in :
                         (cnt_q == CW'(1) && upper) ? status_in : rf_rd_data;

  assign rf_wr_en      = hs && is_load && (cnt_q >= CW'(2));
  assign rf_wr_bank    = cnt_q[3];
  assign rf_wr_idx     = gidx;
  assign rf_wr_data    = mem_rdata;
endmodule

// File: rtl/ctx_xfer_seq_chk.sv
module ctx_xfer_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] base_addr,
  input logic          busy,
  input logic          done,
  input logic          trap_mem,
  input logic          trap_align,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic          rf_wr_en,
  input logic          rf_wr_bank,
  input logic [3:0]    rf_wr_idx
);
  a_r1_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_mem && trap_align));

  a_r2_periph_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && base_addr[AW-1 -: 4] == 4'hF)
    |=> (trap_mem && !trap_align && !mem_req_valid && !rf_wr_en));

  a_r3_align_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && base_addr[AW-1 -: 4] != 4'hF && base_addr[5:0] != 6'd0)
    |=> (trap_align && !busy && !mem_req_valid));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready)
    |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready)
    |=> (!mem_req_valid || mem_req_addr == $past(mem_req_addr) + 4));

  a_r7_target: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (!mem_req_we && (rf_wr_bank || rf_wr_idx[2:0] >= 3'd2)));

  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req_valid));

  a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (!trap_mem && !trap_align));
endmodule

bind ctx_xfer_seq ctx_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
  .busy(busy), .done(done), .trap_mem(trap_mem), .trap_align(trap_align),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .rf_wr_en(rf_wr_en), .rf_wr_bank(rf_wr_bank), .rf_wr_idx(rf_wr_idx)
);

// File: tb/test_ctx_xfer_seq.sv
`timescale 1ns/1ps
module test_ctx_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [31:0] base_addr, link_in, status_in;
  logic        busy, done, trap_mem, trap_align;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata;
  logic        rf_rd_bank, rf_wr_en, rf_wr_bank;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data;

  always #4 clk = ~clk;

  ctx_xfer_seq i_ctx_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
    .link_in(link_in), .status_in(status_in), .busy(busy), .done(done),
    .trap_mem(trap_mem), .trap_align(trap_align),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata),
    .rf_rd_bank(rf_rd_bank), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_bank(rf_wr_bank), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data)
  );

  logic [31:0] mem [0:255];
  logic [31:0] a_rf [0:15];
  logic [31:0] d_rf [0:15];
  logic [31:0] a_old [0:15];
  logic [31:0] d_old [0:15];
  int cyc = 0, ready_mode = 0;
  int checks = 0, errors = 0, hs_cnt = 0, bad_addr = 0, bad_we = 0, trap_seen = 0;
  logic [31:0] exp_base = 0;
  logic exp_we = 0;
  logic finished = 0;

  assign mem_req_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 != 1);
  assign mem_rdata     = mem[mem_req_addr[9:2]];
  assign rf_rd_data    = rf_rd_bank ? d_rf[rf_rd_idx] : a_rf[rf_rd_idx];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (trap_mem || trap_align) trap_seen <= trap_seen + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_addr != exp_base + 32'(hs_cnt) * 4) bad_addr <= bad_addr + 1;
      if (mem_req_we != exp_we) bad_we <= bad_we + 1;
      hs_cnt <= hs_cnt + 1;
      if (mem_req_we) mem[mem_req_addr[9:2]] <= mem_req_wdata;
    end
    if (rf_wr_en) begin
      if (rf_wr_bank) d_rf[rf_wr_idx] <= rf_wr_data;
      else            a_rf[rf_wr_idx] <= rf_wr_data;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] b, input int k);
    return 32'h5A00_0000 ^ (b << 8) ^ (32'(k) * 32'h0101_0101);
  endfunction

  task automatic prime(input int seed, input logic [31:0] b);
    for (int i = 0; i < 16; i++) begin
      a_rf[i] = 32'hA000_0000 | (32'(seed) << 8) | 32'(i);
      d_rf[i] = 32'hD000_0000 | (32'(seed) << 8) | 32'(i);
      a_old[i] = a_rf[i];
      d_old[i] = d_rf[i];
    end
    for (int k = 0; k < 16; k++) mem[b[9:2] + 8'(k)] = pat(b, k);
    link_in   = 32'h1111_0000 | 32'(seed);
    status_in = 32'h5555_0000 | 32'(seed);
  endtask

  task automatic launch(input logic [1:0] o, input logic [31:0] b);
    @(negedge clk);
    op = o; base_addr = b; start = 1'b1;
    hs_cnt = 0; bad_addr = 0; bad_we = 0; trap_seen = 0;
    exp_base = b; exp_we = !o[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int t = 0; t < 200; t++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_regs(input logic [1:0] o, input string tag);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] ea, ed;
      ea = a_old[i]; ed = d_old[i];
      if (o == 2'd1) begin
        if (i >= 2 && i <= 7) ea = pat(exp_base, i);
        if (i < 8) ed = pat(exp_base, i + 8);
      end else if (o == 2'd3) begin
        if (i >= 10) ea = pat(exp_base, i - 8);
        if (i >= 8) ed = pat(exp_base, i);
      end
      check(a_rf[i] == ea, $sformatf("%s A%0d", tag, i), a_rf[i], ea);
      check(d_rf[i] == ed, $sformatf("%s D%0d", tag, i), d_rf[i], ed);
    end
  endtask

  task automatic check_mem(input logic [1:0] o, input string tag);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] e, got;
      got = mem[exp_base[9:2] + 8'(k)];
      if (o == 2'd0) begin
        if (k == 0) e = link_in;
        else if (k == 1) e = a_old[11];
        else if (k < 8) e = a_old[k];
        else e = d_old[k - 8];
      end else begin
        if (k == 0) e = link_in;
        else if (k == 1) e = status_in;
        else if (k < 8) e = a_old[k + 8];
        else e = d_old[k];
      end
      check(got == e, $sformatf("%s slot%0d", tag, k), got, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [3];
    bit seen;
    bases[0] = 32'h0000_0000; bases[1] = 32'h0000_0040; bases[2] = 32'h0000_03C0;
    rst_n = 1'b0; start = 1'b0; op = 2'd0; base_addr = '0;
    link_in = '0; status_in = '0;
    prime(0, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, trap_mem, trap_align, mem_req_valid, rf_wr_en} == 6'b0,
          "R1 reset outputs", {26'b0, busy, done, trap_mem, trap_align, mem_req_valid, rf_wr_en}, 32'h0);

    for (int rm = 0; rm < 2; rm++) begin
      ready_mode = rm;
      for (int o = 0; o < 4; o++) begin
        for (int bi = 0; bi < 3; bi++) begin
          prime(rm * 16 + o * 4 + bi, bases[bi]);
          launch(2'(o), bases[bi]);
          wait_done(seen);
          check(seen, "R9 done raised", 32'(seen), 32'h1);
          check(hs_cnt == 16, "R9 sixteen requests", 32'(hs_cnt), 32'd16);
          check(!busy, "R9 idle with done", 32'(busy), 32'h0);
          check(bad_addr == 0, "R4 slot addresses", 32'(bad_addr), 32'h0);
          check(bad_we == 0, "R11 write enable", 32'(bad_we), 32'h0);
          @(negedge clk);
          check(!done, "R9 single-cycle done", 32'(done), 32'h0);
          if (o == 0)      check_mem(2'd0, "R5 lower save");
          else if (o == 2) check_mem(2'd2, "R6 upper save");
          else if (o == 1) check_regs(2'd1, "R7 lower restore");
          else             check_regs(2'd3, "R8 upper restore");
        end
      end
    end
    ready_mode = 0;

    prime(7, 32'h0000_0040);
    launch(2'd0, 32'hF000_0040);
    check(trap_mem && !trap_align, "R2 peripheral trap", {30'b0, trap_mem, trap_align}, 32'h2);
    @(negedge clk);
    check(!trap_mem, "R2 trap one cycle", 32'(trap_mem), 32'h0);
    repeat (20) @(negedge clk);
    check(hs_cnt == 0 && !busy, "R2 no requests", 32'(hs_cnt), 32'h0);

    launch(2'd1, 32'hF000_0004);
    check(trap_mem && !trap_align, "R2 priority over alignment", {30'b0, trap_mem, trap_align}, 32'h2);
    repeat (20) @(negedge clk);
    check(hs_cnt == 0, "R2 no requests when both", 32'(hs_cnt), 32'h0);
    check_regs(2'd0, "R2 regs untouched");

    launch(2'd3, 32'h0000_0044);
    check(trap_align && !trap_mem, "R3 alignment trap", {30'b0, trap_mem, trap_align}, 32'h1);
    @(negedge clk);
    check(!trap_align, "R3 trap one cycle", 32'(trap_align), 32'h0);
    repeat (20) @(negedge clk);
    check(hs_cnt == 0 && !busy, "R3 no requests", 32'(hs_cnt), 32'h0);
    check_regs(2'd0, "R3 regs untouched");

    ready_mode = 1;
    prime(9, 32'h0000_0080);
    launch(2'd0, 32'h0000_0080);
    @(negedge clk);
    op = 2'd3; base_addr = 32'hF000_0000; start = 1'b1;
    @(negedge clk);
    op = 2'd1; base_addr = 32'h0000_0004;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    check(seen && hs_cnt == 16, "R10 transfer unchanged", 32'(hs_cnt), 32'd16);
    check(trap_seen == 0, "R10 no trap while busy", 32'(trap_seen), 32'h0);
    check(bad_we == 0 && bad_addr == 0, "R10 requests unchanged", 32'(bad_we + bad_addr), 32'h0);
    @(negedge clk);
    check_mem(2'd0, "R10 saved frame");
    check_regs(2'd0, "R10 regs untouched");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule